// File: doc/BRIEF.md
# Reloadable 16-bit Down Timer

This block is a 16-bit down counter with a reload latch, reached over an 8-bit register bus. Each count pulse lowers the counter by one. A pulse that arrives while the counter holds zero causes an underflow: the counter takes the latch value, keeps counting, and raises a sticky interrupt flag. The count pulse comes from one of two places. The first is a one-cycle strobe, `src_tick`, which the surrounding chip generates at the system clock divided by 16. The second is an external pin, which is synchronised inside the block.

A 2-bit mode field selects one of four behaviours:
- plain timing;
- pulse output, where an output pin toggles on each underflow;
- event counting on pin edges;
- pulse-width measurement, where strobes are counted only while the pin sits at an active level.

One polarity bit serves all modes. It selects the edge in event mode, the active level in width mode, and the starting output level in pulse mode.

The 16-bit value is accessed one byte at a time, in a fixed order. A write sends the low byte first; it waits in a buffer until the high byte arrives. A read takes the high byte first, and that read freezes the low byte for the read that follows. A latch-only bit selects where writes land: in the latch alone, or in both the latch and the counter. A stop bit freezes the count.

Top module: `timer16_unit`

## Requirements
- R1: While not stopped, each count pulse that finds the counter non-zero lowers it by exactly one.
- R2: A count pulse that finds the counter at zero reloads it from the latch and sets `irq` to 1 on the following clock.
- R3: `irq` stays 1 until `irq_clr` is pulsed. If an underflow and `irq_clr` occur in the same cycle, the set wins.
- R4: A read at address 1 returns counter bits 15:8 and captures bits 7:0. A later read at address 0 returns that captured byte, even if the counter has moved on since.
- R5: A write to address 0 only buffers the low byte and leaves the counter unchanged. A write to address 1 commits `{data, buffered low}` as one 16-bit value.
- R6: With control bit 3 (latch-only) at 1, a high-byte write changes only the latch, and the counter takes the new value at its next underflow. With bit 3 at 0, the write loads both the latch and the counter.
- R7: While control bit 4 (stop) is 1, the counter holds its value. When the bit is cleared, counting resumes from the held value.
- R8: In mode 01 (pulse output), `pulse_out` toggles on each underflow. A control write sets `pulse_out` to the written control bit 2.
- R9: In mode 10 (event), the count pulse is a synchronised pin edge: rising when bit 2 = 0, falling when bit 2 = 1. `src_tick` is ignored in this mode.
- R10: In mode 11 (width), a `src_tick` counts only while the synchronised pin is high (bit 2 = 0) or low (bit 2 = 1).
- R11: After reset, the counter and latch are 0xFFFF, the control register is 0, `irq` is 0 and `pulse_out` is 0.
- R12: The control register at address 2 reads back its written bits 4:0, with bits 7:5 read as 0. Modes 00 and 01 count `src_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | 0 = count low, 1 = count high, 2 = control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read at address 1 captures the low byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| src_tick | input | 1 | One-cycle strobe from the system clock divided by 16 |
| ext_pin | input | 1 | Asynchronous external counter pin |
| irq_clr | input | 1 | Clears the interrupt request flag |
| pulse_out | output | 1 | Pulse output pin |
| irq | output | 1 | Sticky interrupt request flag |

## Verification
A corrupted counter or latch shows up on `bus_rdata` at the next high-then-low read pair. It also shows up on `irq` when the next underflow comes early or late, which is at most one reload period later. A wrong synchroniser or edge-register state shifts event and width counts by one pulse, and this appears on the very next read. A stale read-hold byte or low-byte buffer is visible on the next low-byte read, or on the next committed 16-bit write. The reference model tracks every register and compares `irq`, `pulse_out` and `bus_rdata` on every clock, so a divergence is reported in the cycle it reaches a port.

// File: rtl/timer16_pkg.sv
// Shared types for the reloadable 16-bit down timer.
// Control byte layout: [1:0] mode, [2] polarity, [3] latch-only, [4] stop.
package timer16_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_WIDTH = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      stop;
        logic      latch_only;
        logic      polarity;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam logic [1:0] ADDR_CNT_LO = 2'd0;
    localparam logic [1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
endpackage

// File: rtl/timer16_pin_sync.sv
// Brings the asynchronous counter pin into the clock domain through a
// chain of STAGES flops. It then compares the result with one edge
// register to flag single-cycle rising and falling edges.
// Assumes STAGES >= 2.
module timer16_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchroniser and keep the last level seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_async};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/timer16_bus_if.sv
// Byte bus front end. It holds the control register, the low-byte write
// buffer and the read-hold byte captured by a high-byte read. It drives
// the read mux combinationally from bus_addr.
// Assumes CNT_W == 2*BUS_W.
module timer16_bus_if
    import timer16_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] cnt_q,
    output tmr_ctrl_t        ctrl,
    output tmr_ctrl_t        ctrl_new,
    output logic             ctrl_wr,
    output logic             hi_wr,
    output logic [CNT_W-1:0] wr_val
);
    localparam int PAD_W = BUS_W - CTRL_W;

    logic [BUS_W-1:0] low_buf;
    logic [BUS_W-1:0] rd_hold;

    assign ctrl_new = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign hi_wr    = bus_wr && (bus_addr == ADDR_CNT_HI);
    assign wr_val   = {bus_wdata, low_buf};

    // Register writes: buffer the low byte (R5) and store the control byte (R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_buf <= '0;
            ctrl    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CNT_LO) low_buf <= bus_wdata;
            if (ctrl_wr)                 ctrl    <= ctrl_new;
        end
    end

    // High-byte read freezes the low byte for the next low read (R4).
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_hold <= '0;
        else if (bus_rd && (bus_addr == ADDR_CNT_HI))
            rd_hold <= cnt_q[BUS_W-1:0];
    end

    // Read mux.
    always_comb begin
        case (bus_addr)
            ADDR_CNT_LO: bus_rdata = rd_hold;
            ADDR_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BUS_W];
            ADDR_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/timer16_counter.sv
// Down counter with reload latch. A direct load from the bus wins over a
// count pulse. A pulse at zero reloads from the latch as it stood before
// this edge.
module timer16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_pulse,
    input  logic             load_latch,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             underflow
);
    logic [CNT_W-1:0] latch_q;

    assign underflow = count_pulse && (cnt_q == '0) && !load_cnt;

    // Reload latch, written by every committed high-byte write (R6).
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '1;
        else if (load_latch) latch_q <= load_val;
    end

    // Counter: bus load, reload on underflow (R2), else decrement (R1).
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '1;
        else if (load_cnt)    cnt_q <= load_val;
        else if (underflow)   cnt_q <= latch_q;
        else if (count_pulse) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/timer16_unit.sv
// Top of the reloadable down timer. Selects the count pulse by mode,
// applies the stop gate, and owns the sticky interrupt flag and the pulse
// output pin. src_tick is a one-cycle strobe in the clk domain.
module timer16_unit
    import timer16_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             src_tick,
    input  logic             ext_pin,
    input  logic             irq_clr,
    output logic             pulse_out,
    output logic             irq
);
    tmr_ctrl_t        ctrl, ctrl_new;
    tmr_mode_e        cur_mode;
    logic             cur_stop;
    logic             ctrl_wr, hi_wr, cnt_load, underflow;
    logic             pin_lvl, pin_rise, pin_fall;
    logic             raw_pulse, cnt_pulse;
    logic [CNT_W-1:0] wr_val, cnt_q;

    assign cur_mode = ctrl.mode;
    assign cur_stop = ctrl.stop;
    assign cnt_load = hi_wr && !ctrl.latch_only;

    timer16_bus_if #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_q(cnt_q), .ctrl(ctrl), .ctrl_new(ctrl_new), .ctrl_wr(ctrl_wr),
        .hi_wr(hi_wr), .wr_val(wr_val)
    );

    timer16_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
        .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    // Count-pulse source by mode (R9, R10, R12).
    always_comb begin
        case (cur_mode)
            MODE_EVENT: raw_pulse = ctrl.polarity ? pin_fall : pin_rise;
            MODE_WIDTH: raw_pulse = src_tick && (pin_lvl != ctrl.polarity);
            default:    raw_pulse = src_tick;
        endcase
    end

    assign cnt_pulse = raw_pulse && !cur_stop;  // R7 stop gate

    timer16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count_pulse(cnt_pulse),
        .load_latch(hi_wr), .load_cnt(cnt_load), .load_val(wr_val),
        .cnt_q(cnt_q), .underflow(underflow)
    );

    // Sticky interrupt request; set beats clear (R3).
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (underflow) irq <= 1'b1;
        else if (irq_clr)   irq <= 1'b0;
    end

    // Pulse output: preset on control write, toggle per underflow (R8).
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_out <= 1'b0;
        else if (ctrl_wr)
            pulse_out <= ctrl_new.polarity;
        else if (underflow && cur_mode == MODE_PULSE)
            pulse_out <= ~pulse_out;
    end
endmodule

// File: rtl/timer16_unit_chk.sv
// Assertion checker for timer16_unit, attached by bind. It watches the
// gated count pulse, the bus load and the counter value against the irq and
// pulse_out ports.
module timer16_unit_chk
    import timer16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             irq_clr,
    input logic             pulse_out,
    input logic             ctrl_wr,
    input tmr_mode_e        cur_mode,
    input logic             cur_stop,
    input logic             cnt_pulse,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt_q
);
    assert_decrement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && cnt_q != '0 && !cnt_load) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

    assert_underflow_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && cnt_q == '0 && !cnt_load) |=> irq);

    assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_stop_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_stop |-> !cnt_pulse);

    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_stop && !cnt_load) |=> $stable(cnt_q));

    assert_pulse_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_PULSE && cnt_pulse && cnt_q == '0 && !cnt_load && !ctrl_wr)
        |=> pulse_out != $past(pulse_out));
endmodule

bind timer16_unit timer16_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_clr(irq_clr),
    .pulse_out(pulse_out), .ctrl_wr(ctrl_wr), .cur_mode(cur_mode),
    .cur_stop(cur_stop), .cnt_pulse(cnt_pulse), .cnt_load(cnt_load),
    .cnt_q(cnt_q)
);

// File: tb/timer16_unit_test.sv
// Testbench: a behavioural reference model, compared on every clock,
// plus directed checks with hand-computed values.
module timer16_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       src_tick = 1'b0, ext_pin = 1'b0, irq_clr = 1'b0;
    logic       pulse_out, irq;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    timer16_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .ext_pin(ext_pin), .irq_clr(irq_clr),
        .pulse_out(pulse_out), .irq(irq)
    );

    // Reference model state
    int m_cnt, m_latch, m_low, m_hold, m_ctrl;
    bit m_irq, m_pout, m_s1, m_s2, m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 16'hFFFF; m_latch = 16'hFFFF; m_low = 0; m_hold = 0; m_ctrl = 0;
            m_irq = 0; m_pout = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            int  mode, newv;
            bit  pol, stop, lonly, p, hiw, ld, uf;
            mode  = m_ctrl & 3;
            pol   = m_ctrl[2];
            lonly = m_ctrl[3];
            stop  = m_ctrl[4];
            if (mode == 2)      p = pol ? (!m_s2 && m_prev) : (m_s2 && !m_prev);
            else if (mode == 3) p = src_tick && (m_s2 == !pol);
            else                p = src_tick;
            if (stop) p = 0;
            hiw  = bus_wr && bus_addr == 1;
            ld   = hiw && !lonly;
            newv = bus_wdata * 256 + m_low;
            uf   = p && m_cnt == 0 && !ld;
            if (bus_rd && bus_addr == 1) m_hold = m_cnt % 256;
            if (ld)      m_cnt = newv;
            else if (uf) m_cnt = m_latch;
            else if (p)  m_cnt = m_cnt - 1;
            if (hiw) m_latch = newv;
            if (uf) m_irq = 1; else if (irq_clr) m_irq = 0;
            if (bus_wr && bus_addr == 2) m_pout = bus_wdata[2];
            else if (uf && mode == 1)    m_pout = !m_pout;
            if (bus_wr && bus_addr == 0) m_low = bus_wdata;
            if (bus_wr && bus_addr == 2) m_ctrl = bus_wdata & 8'h1F;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (running) begin
            int exp_rd;
            case (bus_addr)
                2'd0: exp_rd = m_hold;
                2'd1: exp_rd = m_cnt / 256;
                2'd2: exp_rd = m_ctrl;
                default: exp_rd = 0;
            endcase
            check(irq == m_irq, "R2/R3 irq vs model", irq, m_irq);
            check(pulse_out == m_pout, "R8 pulse_out vs model", pulse_out, m_pout);
            check(bus_rdata == exp_rd, "R4 rdata vs model", bus_rdata, exp_rd);
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic wr16(input int v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic rd16(output int v);
        bus_addr = 2'd1; bus_rd = 1'b1;
        @(negedge clk); v = bus_rdata * 256;
        cyc();
        bus_rd = 1'b0; bus_addr = 2'd0;
        @(negedge clk); v = v + bus_rdata;
        cyc();
    endtask

    task automatic tick(input int n);
        repeat (n) begin src_tick = 1'b1; cyc(); src_tick = 1'b0; cyc(); end
    endtask

    task automatic pin_pulse(input int n);
        repeat (n) begin ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4); end
    endtask

    task automatic expect16(input int exp, input string tag);
        int v;
        rd16(v);
        check(v == exp, tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        running = 1'b1;
        cyc();
        // R11 reset state
        check(irq == 0, "R11 irq after reset", irq, 0);
        check(pulse_out == 0, "R11 pulse_out after reset", pulse_out, 0);
        expect16(16'hFFFF, "R11 counter after reset");
        bus_addr = 2'd2; @(negedge clk);
        check(bus_rdata == 0, "R11 control after reset", bus_rdata, 0);
        cyc(); bus_addr = 2'd0;

        // R5 low byte alone does not change the counter
        wr(2'd0, 8'h03);
        expect16(16'hFFFF, "R5 low write buffered only");
        wr(2'd1, 8'h00);
        expect16(16'h0003, "R5 high write commits both bytes");

        // R1 decrement, R12 timer mode counts src_tick
        tick(2);
        expect16(16'h0001, "R1 decrement per tick");
        tick(1);
        check(irq == 0, "R2 no irq on reaching zero", irq, 0);
        tick(1);
        expect16(16'h0003, "R2 reload from latch at underflow");
        check(irq == 1, "R2 irq set on underflow", irq, 1);

        // R3 sticky until cleared
        tick(2);
        check(irq == 1, "R3 irq held", irq, 1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        check(irq == 0, "R3 irq cleared", irq, 0);

        // R4 captured low byte (counter 1 -> 0 between the reads)
        bus_addr = 2'd1; bus_rd = 1'b1; cyc(); bus_rd = 1'b0; bus_addr = 2'd0;
        tick(1);
        @(negedge clk);
        check(bus_rdata == 8'h01, "R4 low byte is the captured one", bus_rdata, 1);
        cyc();

        // R12 control read-back
        wr(2'd2, 8'hFA);
        bus_addr = 2'd2; @(negedge clk);
        check(bus_rdata == 8'h1A, "R12 control read-back", bus_rdata, 8'h1A);
        cyc(); bus_addr = 2'd0;

        // R7 stop and resume
        wr(2'd2, 8'h10);
        wr16(16'h0100);
        tick(3);
        expect16(16'h0100, "R7 held while stopped");
        wr(2'd2, 8'h00);
        tick(3);
        expect16(16'h00FD, "R7 resumes from held value");

        // R6 latch-only writes
        wr16(16'h0001);
        wr(2'd2, 8'h08);
        wr16(16'h0005);
        expect16(16'h0001, "R6 counter untouched by latch-only write");
        tick(2);
        expect16(16'h0005, "R6 new latch taken at underflow");
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;

        // R8 pulse output, starting level 1
        wr(2'd2, 8'h05);
        check(pulse_out == 1, "R8 start level from polarity", pulse_out, 1);
        wr16(16'h0001);
        tick(1);
        check(pulse_out == 1, "R8 no toggle without underflow", pulse_out, 1);
        tick(1);
        check(pulse_out == 0, "R8 toggle on first underflow", pulse_out, 0);
        tick(2);
        check(pulse_out == 1, "R8 toggle on second underflow", pulse_out, 1);
        wr(2'd2, 8'h01);
        check(pulse_out == 0, "R8 start level 0", pulse_out, 0);

        // R9 event counting, rising then falling
        wr(2'd2, 8'h02);
        wr16(16'h0010);
        tick(2);
        pin_pulse(3);
        expect16(16'h000D, "R9 rising edges counted, ticks ignored");
        wr(2'd2, 8'h06);
        wr16(16'h0010);
        pin_pulse(2);
        expect16(16'h000E, "R9 falling edges counted");

        // R10 pulse-width measurement
        wr(2'd2, 8'h03);
        wr16(16'h0010);
        tick(2);
        ext_pin = 1'b1; cyc(4);
        tick(3);
        ext_pin = 1'b0; cyc(4);
        tick(2);
        expect16(16'h000D, "R10 ticks counted only while pin high");
        wr(2'd2, 8'h07);
        wr16(16'h0010);
        tick(2);
        expect16(16'h000E, "R10 active-low level counts");

        cyc(4);
        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule